// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block decides when a multiphase buck controller may leave shutdown and how its reference climbs to the requested output voltage. Its inputs are digitized comparator results: power-on-reset flags for the logic supply and for three driver supplies, two threshold flags (the main enable and the external-driver enable), a voltage code, a mode select, a phase-count select and a flag that says the output sits inside its regulation window. Its outputs are an output-enable for the PWM pins (low means the pins float), a reference code with a flag that marks a ramp in progress, and a power-good flag.

In the two boot-stage modes, start-up passes through a fixed delay, a ramp to a boot code, a timed hold, a check of the voltage code and a second ramp to the target. In the two direct modes, the reference climbs straight from zero to the target. When any enable condition is lost, the block goes back to shutdown. It starts the full sequence again once every condition holds.

Top module: `vr_startup_seq`

## Requirements
- R1: After reset and in shutdown, pwm_oe is 0 (PWM pins high impedance), ref_code is 0, ramp_en is 0 and pgood is 0.
- R2: Shutdown is left on the clock edge after por_logic, en_ok, drv_en_ok and drv_por[0] are all 1 together. Leaving shutdown is seen as pwm_oe rising.
- R3: When phase_cfg is 2'd2 or 2'd3, drv_por[1] and drv_por[2] must also be 1. For phase_cfg 2'd0 and 2'd1, those two flags are ignored.
- R4: With mode 2'b11 (direct, 5-bit code), a vid[4:0] of 5'h1f means no load, and the block stays in shutdown. In that mode vid[5] is ignored.
- R5: In the boot-stage modes (mode[1]=0), the following happens after start. A delay of TD1_CYC cycles runs with ramp_en low. Then ref_code ramps from 0 to BOOT_CODE. Then BOOT_CODE is held for TD3_CYC cycles with ramp_en low.
- R6: At the end of the hold, vid is sampled. A code is valid unless it is all zeros or all ones. For a valid code, the target is vid as an unsigned number, and the second ramp runs from BOOT_CODE toward it. Changes to vid after sampling have no effect.
- R7: An invalid code at the end of the hold keeps ref_code at BOOT_CODE, ramp_en low and pgood low. The second ramp starts on the edge after a valid code appears.
- R8: In the direct modes (mode[1]=1), the target is latched at start and the reference ramps from 0 to it at once. The target is vid in mode 2'b10 and vid[4:0] in mode 2'b11.
- R9: While pwm_oe is 1, ref_code moves by at most one per cycle. It changes only on a cycle after ramp_en was high, one step every STEP_CYC cycles. A ramp stage ends one cycle after ref_code reaches its goal.
- R10: pgood is 1 exactly when the sequence has completed and vout_ok is 1.
- R11: Losing any enable condition forces shutdown on the next edge, which drops pgood. The next start repeats the full sequence from the TD1_CYC delay.
- R12: In boot-stage modes with a valid code v, pgood is first seen TD1_CYC + BOOT_CODE*STEP_CYC + TD3_CYC + |v-BOOT_CODE|*STEP_CYC + 3 cycles after the start conditions are applied. In direct modes with target t, it is t*STEP_CYC + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_logic | input | 1 | Logic supply past its POR threshold |
| drv_por | input | 3 | Driver supply POR flags, bit i for driver supply i+1 |
| en_ok | input | 1 | Main enable above threshold |
| drv_en_ok | input | 1 | External-driver enable above threshold |
| phase_cfg | input | 2 | Phase configuration; 2 and 3 need all three driver supplies |
| mode | input | 2 | 00/01 boot-stage, 10 direct 6-bit, 11 direct 5-bit |
| vid | input | VID_W | Requested voltage code |
| vout_ok | input | 1 | Output within regulation window |
| pwm_oe | output | 1 | PWM output enable; 0 leaves the pins floating |
| ref_code | output | CODE_W | Soft-start reference code |
| ramp_en | output | 1 | A ramp stage is active |
| pgood | output | 1 | Power good |

## Verification
On every cycle, the assertions check the following:
- the shutdown outputs, and that shutdown holds while a driver-supply condition or the no-load code is present;
- that shutdown follows the loss of a supply or threshold flag;
- that pgood only coexists with vout_ok and a finished ramp;
- that the reference moves by single steps and only during ramps.

Only the bench scenarios can show the stage lengths, the full latency per code and the latching of the code at the end of the hold. The same holds for recovery from an invalid code and for the exact set of enable combinations that allow start-up.

// File: rtl/vr_startup_seq.sv
module vr_startup_seq #(
  parameter int VID_W     = 6,
  parameter int CODE_W    = 8,
  parameter int TD1_CYC   = 10,
  parameter int TD3_CYC   = 12,
  parameter int STEP_CYC  = 3,
  parameter int BOOT_CODE = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_logic,
  input  logic [2:0]        drv_por,
  input  logic              en_ok,
  input  logic              drv_en_ok,
  input  logic [1:0]        phase_cfg,
  input  logic [1:0]        mode,
  input  logic [VID_W-1:0]  vid,
  input  logic              vout_ok,
  output logic              pwm_oe,
  output logic [CODE_W-1:0] ref_code,
  output logic              ramp_en,
  output logic              pgood
);
  localparam int TD_MAX = (TD1_CYC > TD3_CYC) ? TD1_CYC : TD3_CYC;
  localparam int CNT_W  = $clog2(TD_MAX + 1);
  localparam int SC_W   = $clog2(STEP_CYC + 1);

  typedef enum logic [2:0] {S_OFF, S_DLY, S_RAMP1, S_HOLD, S_WAIT, S_RAMP2, S_RUN} st_t;

  st_t               st;
  logic [CODE_W-1:0] ref_q, tgt, goal, vid_code;
  logic [CNT_W-1:0]  cnt;
  logic [SC_W-1:0]   sc;
  logic              en_all, direct, five, noload, vid_valid, at_goal, tick;

  assign en_all    = por_logic & en_ok & drv_en_ok & drv_por[0] &
                     (~phase_cfg[1] | (drv_por[1] & drv_por[2]));
  assign direct    = mode[1];
  assign five      = mode[1] & mode[0];
  assign noload    = five & (&vid[4:0]);
  assign vid_code  = five ? CODE_W'(vid[4:0]) : CODE_W'(vid);
  assign vid_valid = (vid != '0) && !(&vid);
  assign goal      = (st == S_RAMP1) ? CODE_W'(BOOT_CODE) : tgt;
  assign at_goal   = (ref_q == goal);
  assign tick      = (sc == SC_W'(STEP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; ref_q <= '0; tgt <= '0; cnt <= '0; sc <= '0;
    end else if (st != S_OFF && !en_all) begin
      st <= S_OFF; ref_q <= '0; cnt <= '0; sc <= '0;
    end else begin
      case (st)
        S_OFF:
          if (en_all && !noload) begin
            cnt <= '0; sc <= '0; ref_q <= '0;
            if (direct) begin
              tgt <= vid_code;
              st  <= S_RAMP2;
            end else begin
              st <= S_DLY;
            end
          end
        S_DLY:
          if (cnt == CNT_W'(TD1_CYC - 1)) begin
            cnt <= '0; sc <= '0; st <= S_RAMP1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_RAMP1, S_RAMP2:
          if (at_goal) begin
            sc <= '0; cnt <= '0;
            st <= (st == S_RAMP1) ? S_HOLD : S_RUN;
          end else if (tick) begin
            sc    <= '0;
            ref_q <= (ref_q < goal) ? ref_q + 1'b1 : ref_q - 1'b1;
          end else begin
            sc <= sc + 1'b1;
          end
        S_HOLD:
          if (cnt == CNT_W'(TD3_CYC - 1)) begin
            cnt <= '0; sc <= '0;
            if (vid_valid) begin
              tgt <= vid_code;
              st  <= S_RAMP2;
            end else begin
              st <= S_WAIT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_WAIT:
          if (vid_valid) begin
            tgt <= vid_code; sc <= '0; st <= S_RAMP2;
          end
        S_RUN: ;
        default: st <= S_OFF;
      endcase
    end
  end

  assign pwm_oe   = (st != S_OFF);
  assign ref_code = ref_q;
  assign ramp_en  = (st == S_RAMP1) || (st == S_RAMP2);
  assign pgood    = (st == S_RUN) && vout_ok;
endmodule

module vr_startup_seq_chk #(
  parameter int VID_W  = 6,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_logic,
  input logic [2:0]        drv_por,
  input logic              en_ok,
  input logic              drv_en_ok,
  input logic [1:0]        phase_cfg,
  input logic [1:0]        mode,
  input logic [VID_W-1:0]  vid,
  input logic              vout_ok,
  input logic              pwm_oe,
  input logic [CODE_W-1:0] ref_code,
  input logic              ramp_en,
  input logic              pgood
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe |-> (ref_code == '0) && !ramp_en && !pgood); // R1
  AST_MULTI_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_oe && phase_cfg[1] && !(drv_por[1] && drv_por[2])) |=> !pwm_oe); // R3
  AST_NOLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_oe && mode == 2'b11 && (&vid[4:0])) |=> !pwm_oe); // R4
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe && $past(pwm_oe)) |-> (ref_code == $past(ref_code)) ||
      (ref_code == $past(ref_code) + CODE_W'(1)) ||
      (ref_code == $past(ref_code) - CODE_W'(1))); // R9
  AST_FROZEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe && $past(pwm_oe) && !$past(ramp_en)) |-> $stable(ref_code)); // R9
  AST_PG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> vout_ok && pwm_oe && !ramp_en); // R10
  AST_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_logic || !en_ok || !drv_en_ok || !drv_por[0]) |=> !pwm_oe); // R11
endmodule

bind vr_startup_seq vr_startup_seq_chk #(.VID_W(VID_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_logic(por_logic), .drv_por(drv_por), .en_ok(en_ok),
  .drv_en_ok(drv_en_ok), .phase_cfg(phase_cfg), .mode(mode), .vid(vid), .vout_ok(vout_ok),
  .pwm_oe(pwm_oe), .ref_code(ref_code), .ramp_en(ramp_en), .pgood(pgood));

// File: tb/vr_startup_seq_test.sv
module vr_startup_seq_test;
  localparam int TD1 = 10, TD3 = 12, STEP = 3, BOOT = 20;

  logic clk = 0, rst_n = 0;
  logic por_logic = 0, en_ok = 0, drv_en_ok = 0, vout_ok = 1;
  logic [2:0] drv_por = 0;
  logic [1:0] phase_cfg = 0, mode = 0;
  logic [5:0] vid = 0;
  logic pwm_oe, ramp_en, pgood;
  logic [7:0] ref_code;
  int checks = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vr_startup_seq #(.VID_W(6), .CODE_W(8), .TD1_CYC(TD1), .TD3_CYC(TD3),
                   .STEP_CYC(STEP), .BOOT_CODE(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .por_logic(por_logic), .drv_por(drv_por), .en_ok(en_ok),
    .drv_en_ok(drv_en_ok), .phase_cfg(phase_cfg), .mode(mode), .vid(vid), .vout_ok(vout_ok),
    .pwm_oe(pwm_oe), .ref_code(ref_code), .ramp_en(ramp_en), .pgood(pgood));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  task automatic all_on();
    por_logic = 1; en_ok = 1; drv_en_ok = 1; drv_por = 3'b111; phase_cfg = 2'd3;
  endtask

  task automatic shut_down();
    en_ok = 0;
    @(negedge clk);
    chk("R11 off after enable loss", pwm_oe, 0);
    chk("R11 pgood low after loss", pgood, 0);
  endtask

  task automatic wait_pg(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pgood && n < 2000);
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pwm_oe", pwm_oe, 0);
    chk("R1 reset ref_code", ref_code, 0);
    chk("R1 reset ramp_en", ramp_en, 0);
    chk("R1 reset pgood", pgood, 0);

    // R2 R3: every enable combination under each phase configuration
    mode = 2'b10; vid = 6'd5;
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int c = 0; c < 64; c++) begin
        bit e;
        phase_cfg = cfg[1:0];
        {por_logic, en_ok, drv_en_ok, drv_por} = c[5:0];
        e = por_logic && en_ok && drv_en_ok && drv_por[0] &&
            (cfg < 2 || (drv_por[1] && drv_por[2]));
        @(negedge clk);
        chk(cfg >= 2 ? "R3 multi-phase gating" : "R2 enable gating", pwm_oe, int'(e));
        if (!e) chk("R1 shutdown ref", ref_code, 0);
        por_logic = 0;
        @(negedge clk);
        chk("R11 off after por loss", pwm_oe, 0);
      end
    end

    // R5 stage timing, R6 latching, R9 step cadence
    begin
      int first_ramp = 0, first_boot = 0, hold_end = 0, first_one = 0;
      mode = 2'b00; vid = 6'd45; all_on();
      for (int k = 1; k < 600 && !pgood; k++) begin
        @(negedge clk);
        if (ramp_en && first_ramp == 0) first_ramp = k;
        if (ref_code == 1 && first_one == 0) first_one = k;
        if (ref_code == BOOT && first_boot == 0) first_boot = k;
        if (first_boot != 0 && !ramp_en && hold_end == 0 && k > first_boot) hold_end = k;
        if (k == TD1 + 2 + BOOT*STEP + TD3) vid = 6'd3;
      end
      chk("R5 delay length", first_ramp, TD1 + 1);
      chk("R9 first step", first_one, TD1 + 1 + STEP);
      chk("R5 reach boot", first_boot, TD1 + 1 + BOOT*STEP);
      chk("R5 hold start", hold_end, TD1 + 2 + BOOT*STEP);
      chk("R6 target kept after vid change", ref_code, 45);
      chk("R10 pgood after sequence", pgood, 1);
      vout_ok = 0;
      @(negedge clk);
      chk("R10 pgood follows vout_ok", pgood, 0);
      vout_ok = 1;
      @(negedge clk);
      chk("R10 pgood returns", pgood, 1);
      shut_down();
    end

    // R6 R7 R12: sweep every code in boot-stage mode
    for (int v = 0; v < 64; v++) begin
      mode = v[0] ? 2'b01 : 2'b00; vid = v[5:0]; all_on();
      if (v == 0 || v == 63) begin
        repeat (TD1 + BOOT*STEP + TD3 + 40) @(negedge clk);
        chk("R7 invalid keeps pgood low", pgood, 0);
        chk("R7 invalid holds boot", ref_code, BOOT);
        chk("R7 invalid no ramp", ramp_en, 0);
        vid = 6'd33;
        wait_pg(n);
        chk("R7 recovery latency", n, absd(33, BOOT)*STEP + 2);
        chk("R7 recovery target", ref_code, 33);
      end else begin
        wait_pg(n);
        chk("R12 boot-mode latency", n, TD1 + BOOT*STEP + TD3 + absd(v, BOOT)*STEP + 3);
        chk("R6 boot-mode target", ref_code, v);
      end
      shut_down();
    end

    // R8 R4 R12: direct modes
    for (int m = 2; m < 4; m++) begin
      for (int v = 0; v < 64; v++) begin
        int t;
        mode = m[1:0]; vid = v[5:0];
        t = (m == 3) ? (v & 31) : v;
        all_on();
        if (m == 3 && (v & 31) == 31) begin
          repeat (5) @(negedge clk);
          chk("R4 no-load code blocks start", pwm_oe, 0);
          chk("R4 ref stays zero", ref_code, 0);
          por_logic = 0;
          @(negedge clk);
        end else begin
          wait_pg(n);
          chk("R12 direct latency", n, t*STEP + 2);
          chk("R8 direct target", ref_code, t);
          shut_down();
        end
      end
    end

    finish_run();
  end
endmodule